// File: doc/BRIEF.md
# Serial Output Frame Word Formatter

This block produces the serial data-out stream of a four-channel converter's SPI port. A frame begins when chip select goes low. It carries a 16-bit response item, then the four 24-bit channel samples in channel order, then a 16-bit check item. Each item sits in one word. A 2-bit length field sets the word length for the whole frame, and each item type follows its own alignment rule inside the word. Every shift-enable pulse from the SCLK domain moves the output to the next bit, most significant bit first.

The length field, the short-frame flag and all parallel items are captured on the first clock on which chip select is seen low. Upstream logic may therefore change them while the frame is being shifted. A frame-done pulse marks that the final word was read out completely, so an upstream data-ready flag can be cleared only on a full read. A short frame, chosen when the converters are off, holds only the response word. Raising chip select at any point returns the block to idle without a done pulse.

Top module: `sfmt_top`

## Requirements
- R1: After reset, and on every clock that follows a clock where cs_n was sampled high, dout is 0 and frame_done is 0.
- R2: On the first clock with cs_n low after idle, dout shows the MSB of word 0. Each later clock with sclk_en high moves dout to the next bit, MSB first. Words are sent in the order response, ch_data[23:0] (channel 0), ch_data[47:24], ch_data[71:48], ch_data[95:72], check.
- R3: Response and check items send their 16 bits first. Any remaining bits of a 24-bit or 32-bit word are zeros.
- R4: wlen_mode 2'b00 gives 16-bit words, and each sample is sent as its upper 16 bits.
- R5: wlen_mode 2'b01 gives 24-bit words, and samples are sent whole.
- R6: wlen_mode 2'b10 gives 32-bit words, and each sample is followed by 8 zero bits.
- R7: wlen_mode 2'b11 gives 32-bit words, and each sample is preceded by 8 copies of its bit 23.
- R8: wlen_mode, short_frame and all data inputs are taken on the frame's first clock. Changes to them later in the frame have no effect on dout.
- R9: With short_frame high at frame start, the frame holds only the response word.
- R10: frame_done is high for exactly one clock, the clock after the sclk_en that consumed the last bit of the final word. Afterwards dout stays 0 until cs_n goes high.
- R11: Raising cs_n before the final word ends the frame with no frame_done pulse. The next frame starts again at word 0, bit 0.
- R12: sclk_en has no effect while cs_n is high or on the frame's first clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low; low starts a frame |
| sclk_en | input | 1 | One-clock pulse per shifted bit |
| wlen_mode | input | 2 | Word length and sample alignment code |
| short_frame | input | 1 | Converters off: response word only |
| rsp_word | input | 16 | Response item |
| ch_data | input | 96 | Four 24-bit samples, channel k at bits [24k+23:24k] |
| chk_word | input | 16 | Check item |
| dout | output | 1 | Registered serial data out |
| frame_done | output | 1 | One-clock pulse after a complete frame |

## Verification
Two events can land on the same clock edge: the shift that consumes the last bit of the final word, and a change of wlen_mode or data intended for the next frame. The bench provokes this by changing the mode and all items in the middle of a frame and again right at its final shift. It also pulses sclk_en on the very clock where chip select first goes low. A queue model built at frame start judges the outcome. It requires that the done pulse and the remaining bits follow only the captured setup, and that the start clock never consumes a bit.

// File: rtl/sfmt_pkg.sv
package sfmt_pkg;
  typedef enum logic [1:0] {
    WL_SHORT = 2'b00,
    WL_MID   = 2'b01,
    WL_LONG0 = 2'b10,
    WL_LONGS = 2'b11
  } wlen_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'b00,
    SQ_SHIFT = 2'b01,
    SQ_END   = 2'b10
  } seq_e;

  function automatic int unsigned wlen_bits(input wlen_e m, input int unsigned s_w,
                                            input int unsigned m_w, input int unsigned l_w);
    case (m)
      WL_SHORT: return s_w;
      WL_MID:   return m_w;
      default:  return l_w;
    endcase
  endfunction
endpackage

// File: rtl/sfmt_word.sv
module sfmt_word
  import sfmt_pkg::*;
#(
  parameter int unsigned CTL_W = 16,
  parameter int unsigned SMP_W = 24,
  parameter int unsigned MAX_W = 32
) (
  input  logic             is_smp,
  input  wlen_e            mode,
  input  logic [CTL_W-1:0] ctl,
  input  logic [SMP_W-1:0] smp,
  output logic [MAX_W-1:0] word
);
  localparam int unsigned PAD_C = MAX_W - CTL_W;
  localparam int unsigned PAD_S = MAX_W - SMP_W;

  always_comb begin
    if (!is_smp) begin
      word = {ctl, {PAD_C{1'b0}}};
    end else begin
      case (mode)
        WL_SHORT: word = {smp[SMP_W-1 -: CTL_W], {PAD_C{1'b0}}};
        WL_LONGS: word = {{PAD_S{smp[SMP_W-1]}}, smp};
        default:  word = {smp, {PAD_S{1'b0}}};
      endcase
    end
  end
endmodule

// File: rtl/sfmt_seq.sv
module sfmt_seq
  import sfmt_pkg::*;
#(
  parameter int unsigned NWORD = 6,
  parameter int unsigned CTL_W = 16,
  parameter int unsigned SMP_W = 24,
  parameter int unsigned MAX_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cs_n,
  input  logic                     sclk_en,
  input  wlen_e                    mode_i,
  input  logic                     short_i,
  output logic                     start_o,
  output logic                     nxt_shift,
  output logic [$clog2(NWORD)-1:0] nxt_widx,
  output logic [$clog2(MAX_W)-1:0] nxt_bidx,
  output wlen_e                    nxt_mode,
  output logic                     done_o
);
  localparam int unsigned WW = $clog2(NWORD);
  localparam int unsigned BW = $clog2(MAX_W);

  seq_e          st_q, st_d;
  logic [WW-1:0] w_q;
  logic [BW-1:0] b_q;
  wlen_e         mode_q;
  logic          short_q, short_d, done_d;
  logic [BW-1:0] blast;
  logic [WW-1:0] wlast;

  assign blast = BW'(wlen_bits(mode_q, CTL_W, SMP_W, MAX_W) - 1);
  assign wlast = short_q ? '0 : WW'(NWORD - 1);

  always_comb begin
    st_d     = st_q;
    nxt_widx = w_q;
    nxt_bidx = b_q;
    nxt_mode = mode_q;
    short_d  = short_q;
    done_d   = 1'b0;
    start_o  = 1'b0;
    if (cs_n) begin
      st_d     = SQ_IDLE;
      nxt_widx = '0;
      nxt_bidx = '0;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          start_o  = 1'b1;
          st_d     = SQ_SHIFT;
          nxt_widx = '0;
          nxt_bidx = '0;
          nxt_mode = mode_i;
          short_d  = short_i;
        end
        SQ_SHIFT: begin
          if (sclk_en) begin
            if (b_q == blast) begin
              if (w_q == wlast) begin
                st_d   = SQ_END;
                done_d = 1'b1;
              end else begin
                nxt_widx = w_q + WW'(1);
                nxt_bidx = '0;
              end
            end else begin
              nxt_bidx = b_q + BW'(1);
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign nxt_shift = (st_d == SQ_SHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SQ_IDLE;
      w_q     <= '0;
      b_q     <= '0;
      mode_q  <= WL_MID;
      short_q <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      st_q    <= st_d;
      w_q     <= nxt_widx;
      b_q     <= nxt_bidx;
      mode_q  <= nxt_mode;
      short_q <= short_d;
      done_o  <= done_d;
    end
  end

  // R2
  bit_range_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_SHIFT) |-> (b_q <= blast));
  // R9
  word_range_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_SHIFT) |-> (w_q <= wlast));
  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_SHIFT && !cs_n) |=> $stable(mode_q));
endmodule

// File: rtl/sfmt_top.sv
module sfmt_top
  import sfmt_pkg::*;
#(
  parameter int unsigned NCH   = 4,
  parameter int unsigned CTL_W = 16,
  parameter int unsigned SMP_W = 24,
  parameter int unsigned MAX_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_n,
  input  logic                 sclk_en,
  input  logic [1:0]           wlen_mode,
  input  logic                 short_frame,
  input  logic [CTL_W-1:0]     rsp_word,
  input  logic [NCH*SMP_W-1:0] ch_data,
  input  logic [CTL_W-1:0]     chk_word,
  output logic                 dout,
  output logic                 frame_done
);
  localparam int unsigned NWORD = NCH + 2;
  localparam int unsigned WW    = $clog2(NWORD);
  localparam int unsigned BW    = $clog2(MAX_W);
  localparam int unsigned CW    = (NCH > 1) ? $clog2(NCH) : 1;

  logic          start, nxt_shift;
  logic [WW-1:0] nxt_widx;
  logic [BW-1:0] nxt_bidx;
  wlen_e         nxt_mode;

  sfmt_seq #(.NWORD(NWORD), .CTL_W(CTL_W), .SMP_W(SMP_W), .MAX_W(MAX_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .sclk_en  (sclk_en),
    .mode_i   (wlen_e'(wlen_mode)),
    .short_i  (short_frame),
    .start_o  (start),
    .nxt_shift(nxt_shift),
    .nxt_widx (nxt_widx),
    .nxt_bidx (nxt_bidx),
    .nxt_mode (nxt_mode),
    .done_o   (frame_done)
  );

  // frame snapshot, loaded on the start clock
  logic [CTL_W-1:0] cap_rsp, cap_chk, src_rsp, src_chk;
  logic [SMP_W-1:0] cap_smp [NCH];
  logic [SMP_W-1:0] src_smp [NCH];

  always_ff @(posedge clk) begin
    if (start) begin
      cap_rsp <= rsp_word;
      cap_chk <= chk_word;
    end
  end
  assign src_rsp = start ? rsp_word : cap_rsp;
  assign src_chk = start ? chk_word : cap_chk;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    always_ff @(posedge clk) begin
      if (start) cap_smp[k] <= ch_data[k*SMP_W +: SMP_W];
    end
    assign src_smp[k] = start ? ch_data[k*SMP_W +: SMP_W] : cap_smp[k];
  end

  logic             is_smp;
  logic [CW-1:0]    ch_idx;
  logic [CTL_W-1:0] ctl_sel;
  logic [MAX_W-1:0] word;

  assign is_smp  = (nxt_widx != '0) && (nxt_widx != WW'(NWORD - 1));
  assign ch_idx  = CW'(nxt_widx - WW'(1));
  assign ctl_sel = (nxt_widx == '0) ? src_rsp : src_chk;

  sfmt_word #(.CTL_W(CTL_W), .SMP_W(SMP_W), .MAX_W(MAX_W)) u_word (
    .is_smp(is_smp),
    .mode  (nxt_mode),
    .ctl   (ctl_sel),
    .smp   (src_smp[ch_idx]),
    .word  (word)
  );

  always_ff @(posedge clk) begin
    if (rst) dout <= 1'b0;
    else     dout <= nxt_shift ? word[BW'(MAX_W - 1) - nxt_bidx] : 1'b0;
  end

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (!dout && !frame_done));
  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);
  // R10
  done_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_done) |-> ($past(sclk_en) && !$past(cs_n)));
  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !dout);
endmodule

// File: tb/sim_sfmt_top.sv
module sim_sfmt_top;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        sclk_en = 1'b0;
  logic [1:0]  wlen_mode = 2'b01;
  logic        short_frame = 1'b0;
  logic [15:0] rsp_word = '0;
  logic [95:0] ch_data = '0;
  logic [15:0] chk_word = '0;
  logic        dout, frame_done;

  always #(CLK_PER/2) clk = ~clk;

  sfmt_top u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk_en(sclk_en), .wlen_mode(wlen_mode),
    .short_frame(short_frame), .rsp_word(rsp_word), .ch_data(ch_data),
    .chk_word(chk_word), .dout(dout), .frame_done(frame_done)
  );

  int    n_chk = 0, n_fail = 0;
  string tag = "R1";

  // behavioural model: bit queue built at frame start
  bit q[$];
  int m_st = 0;
  bit e_dout = 0, e_done = 0;

  function automatic void push_ctl(input logic [15:0] v, input int len);
    for (int i = 15; i >= 0; i--) q.push_back(v[i]);
    for (int i = 16; i < len; i++) q.push_back(1'b0);
  endfunction

  function automatic void push_smp(input logic [23:0] s, input logic [1:0] m);
    if (m == 2'b11) for (int i = 0; i < 8; i++) q.push_back(s[23]);
    for (int i = 23; i >= ((m == 2'b00) ? 8 : 0); i--) q.push_back(s[i]);
    if (m == 2'b10) for (int i = 0; i < 8; i++) q.push_back(1'b0);
  endfunction

  function automatic void build();
    int len;
    len = (wlen_mode == 2'b00) ? 16 : (wlen_mode == 2'b01) ? 24 : 32;
    q.delete();
    push_ctl(rsp_word, len);
    if (!short_frame) begin
      for (int c = 0; c < 4; c++) push_smp(ch_data[c*24 +: 24], wlen_mode);
      push_ctl(chk_word, len);
    end
  endfunction

  always @(posedge clk) begin
    if (rst || cs_n) begin
      m_st = 0; q.delete(); e_dout = 0; e_done = 0;
    end else if (m_st == 0) begin
      build(); m_st = 1; e_dout = q[0]; e_done = 0;
    end else if (m_st == 1 && sclk_en) begin
      void'(q.pop_front());
      if (q.size() == 0) begin m_st = 2; e_done = 1; e_dout = 0; end
      else e_dout = q[0];
    end else e_done = 0;
  end

  always @(negedge clk) begin
    if (!rst) begin
      n_chk++;
      if (dout !== e_dout) begin
        n_fail++;
        $display("FAIL %s dout: actual %b expected %b at %0t", tag, dout, e_dout, $time);
      end
      n_chk++;
      if (frame_done !== e_done) begin
        n_fail++;
        $display("FAIL R10 %s frame_done: actual %b expected %b at %0t", tag, frame_done, e_done, $time);
      end
    end
  end

  task automatic idle(input int n);
    cs_n = 1'b1;
    for (int i = 0; i < n; i++) begin
      sclk_en = i[0];  // R12: pulses while deselected
      @(negedge clk);
    end
    sclk_en = 1'b0;
  endtask

  // gap: idle clocks between shifts; stop_at: shift count for early end (0 = none)
  task automatic frame(input logic [1:0] m, input bit sh, input int gap,
                       input int stop_at, input bit perturb);
    int shifts = 0;
    wlen_mode = m; short_frame = sh;
    rsp_word = 16'($urandom); chk_word = 16'($urandom);
    ch_data = {24'h80_1234 ^ 24'($urandom & 32'h7F), 24'h7F_0001,
               24'($urandom), 24'hC3_5A96};
    cs_n = 1'b0;
    sclk_en = 1'b1;  // R12: start clock must not shift
    @(negedge clk);
    while (m_st != 2 && (stop_at == 0 || shifts < stop_at)) begin
      sclk_en = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
      sclk_en = 1'b1;
      shifts++;
      if (perturb && (shifts == 20 || q.size() == 1)) begin  // R8
        wlen_mode = ~wlen_mode; short_frame = ~short_frame;
        rsp_word = ~rsp_word; ch_data = ~ch_data; chk_word = ~chk_word;
      end
      @(negedge clk);
    end
    sclk_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tag = "R1 R12"; idle(6);
    tag = "R2 R3 R5"; frame(2'b01, 1'b0, 0, 0, 1'b0); idle(2);
    tag = "R4 R3";    frame(2'b00, 1'b0, 1, 0, 1'b0); idle(2);
    tag = "R6 R3";    frame(2'b10, 1'b0, 2, 0, 1'b0); idle(2);
    tag = "R7 R3";    frame(2'b11, 1'b0, 0, 0, 1'b0); idle(2);
    tag = "R7 sign";  ch_data = '0; frame(2'b11, 1'b0, 1, 0, 1'b0); idle(1);
    tag = "R8";       frame(2'b10, 1'b0, 0, 0, 1'b1); idle(2);
    tag = "R8 short"; frame(2'b00, 1'b0, 1, 0, 1'b1); idle(2);
    tag = "R9";       frame(2'b11, 1'b1, 0, 0, 1'b0); idle(2);
    tag = "R9 mid";   frame(2'b01, 1'b1, 2, 0, 1'b0); idle(2);
    tag = "R11";      frame(2'b01, 1'b0, 0, 37, 1'b0); idle(1);
    tag = "R11 again"; frame(2'b10, 1'b0, 0, 5, 1'b0); idle(3);
    tag = "R11 after"; frame(2'b00, 1'b0, 0, 0, 1'b0); idle(2);
    tag = "R1 reset"; rst = 1'b1; @(negedge clk); rst = 1'b0; idle(3);
    finish_run();
  end
endmodule